// File: doc/BRIEF.md
# Multiplex-Aware Frame Timing Generator

This block turns a free-running oscillator clock (nominally 12288 Hz) into the timing that a multiplexed dot-matrix display driver needs. It produces a slower cascade clock for companion column drivers, a one-cycle strobe that marks each cascade clock period, a frame sync pulse, and a row index for the row sequencer. The division ratio follows the selected multiplex rate. At 1:8, 1:16 and 1:32 the oscillator is divided by 6 and a frame spans 32 cascade clocks. At 1:24 it is divided by 8 and a frame spans 24 cascade clocks. Both settings give 192 oscillator cycles per frame, so the frame rate is a nominal 64 Hz whatever the multiplex rate.

Control is a two-state machine. In `ST_LOAD`, the reset state, all outputs are held low. The transition `LOAD_TO_RUN` happens on the first oscillator edge after reset is released: it captures the rate select and starts the first frame. `ST_RUN` then loops on itself with no end. Its one named transition, `RUN_FRAME_WRAP`, takes place on the last oscillator cycle of a frame and loads a new rate select. A rate change requested in the middle of a frame therefore waits for the boundary and never cuts a frame short or stretches it.

The row index counts across the frame. At 1:24 and 1:32 it runs 0 to N-1 once per frame. At 1:8 and 1:16 the sequence repeats within the 32-slot frame, four times and twice respectively.

Top module: `frame_timing_gen`

## Requirements
- R1: While reset is low, and between reset release and the first rising oscillator edge, cas_clk_o, cas_clk_en_o and sync_o are 0 and row_idx_o is 0.
- R2: In run, the cascade clock period is 8 oscillator cycles when the active rate select is 2 (1:24) and 6 for selects 0 (1:8), 1 (1:16) and 3 (1:32). cas_clk_en_o is high for exactly the first oscillator cycle of each period. cas_clk_o is high for the first half of the period (3 or 4 cycles) and low for the rest.
- R3: sync_o is high for exactly one cascade clock period, the first slot of each frame. Successive rising edges of sync_o are always 192 oscillator cycles apart, whatever the rate.
- R4: A frame contains 32 cascade clock periods at the divide-by-6 setting and 24 at the divide-by-8 setting.
- R5: row_idx_o equals the slot number within the frame, taken modulo N, where N is 8, 16, 24 or 32 for selects 0, 1, 2 and 3.
- R6: A new value on mux_sel_i is adopted only at a frame boundary. The frame in progress keeps its division ratio and length.
- R7: The first cascade clock strobe and the first sync pulse appear on the first oscillator cycle after the first rising edge that follows reset release.
- R8: After reset is released, the cascade clock keeps toggling without pause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mux_sel_i | input | 2 | Multiplex rate select: 0=1:8, 1=1:16, 2=1:24, 3=1:32 |
| cas_clk_o | output | 1 | Cascade clock level, high for the first half of each period |
| cas_clk_en_o | output | 1 | One-oscillator-cycle strobe at the start of each cascade clock period |
| sync_o | output | 1 | Frame sync, high during slot 0 of each frame |
| row_idx_o | output | 5 | Active row index |

## Verification
The bench switches the rate select at random points inside frames, including the last oscillator cycle before a boundary. A design that adopts the new value at once would produce a frame whose strobe count is neither 32 nor 24 and whose sync spacing is not 192 cycles. It also applies reset in the middle of a frame and checks that the first strobe and sync follow the first edge after release; an extra idle cycle or a stale counter would shift that edge. At 1:8 and 1:16 the row index must fold back to zero inside the frame, and a wrong mask would show up as rows beyond N-1. At 1:24 the bench checks that both the slower divide and the shorter frame are applied; a design that applied only one of them would drift away from the 192-cycle frame.

// File: rtl/ftg_pkg.sv
package ftg_pkg;

    typedef enum logic [1:0] {
        MUX_8  = 2'd0,
        MUX_16 = 2'd1,
        MUX_24 = 2'd2,
        MUX_32 = 2'd3
    } mux_rate_e;

    typedef enum logic {
        ST_LOAD = 1'b0,
        ST_RUN  = 1'b1
    } ftg_state_e;

endpackage

// File: rtl/ftg_ctrl.sv
module ftg_ctrl
    import ftg_pkg::*;
#(
    parameter int DIV_STD   = 6,
    parameter int DIV_ALT   = 8,
    parameter int FRAME_STD = 32,
    parameter int FRAME_ALT = 24,
    parameter int DIV_W     = 3,
    parameter int SLOT_W    = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  mux_rate_e         rate_req_i,
    input  logic              frame_end_i,
    output logic              run_o,
    output mux_rate_e         rate_o,
    output logic [DIV_W-1:0]  div_last_o,
    output logic [DIV_W-1:0]  div_half_o,
    output logic [SLOT_W-1:0] slot_last_o
);

    ftg_state_e state_q, state_d;
    mux_rate_e  rate_q, rate_d;

    // state register process
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_LOAD;
            rate_q  <= MUX_32;
        end else begin
            state_q <= state_d;
            rate_q  <= rate_d;
        end
    end

    // next state and outputs process
    always_comb begin
        state_d = state_q;
        rate_d  = rate_q;
        unique case (state_q)
            ST_LOAD: begin
                // LOAD_TO_RUN
                state_d = ST_RUN;
                rate_d  = rate_req_i;
            end
            ST_RUN: begin
                // RUN_FRAME_WRAP
                if (frame_end_i) begin
                    rate_d = rate_req_i;
                end
            end
            default: state_d = ST_LOAD;
        endcase

        run_o  = (state_q == ST_RUN);
        rate_o = rate_q;
        if (rate_q == MUX_24) begin
            div_last_o  = DIV_W'(DIV_ALT - 1);
            div_half_o  = DIV_W'(DIV_ALT / 2);
            slot_last_o = SLOT_W'(FRAME_ALT - 1);
        end else begin
            div_last_o  = DIV_W'(DIV_STD - 1);
            div_half_o  = DIV_W'(DIV_STD / 2);
            slot_last_o = SLOT_W'(FRAME_STD - 1);
        end
    end

    // R6: active rate only moves at a frame boundary
    a_r6_rate_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_RUN && !frame_end_i) |=> $stable(rate_q));

    // R1/R7: load lasts exactly one edge
    a_r7_single_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_LOAD) |=> (state_q == ST_RUN));

endmodule

// File: rtl/ftg_prescaler.sv
module ftg_prescaler #(
    parameter int DIV_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_last_i,
    input  logic [DIV_W-1:0] div_half_i,
    output logic             clk_en_o,
    output logic             clk_lvl_o,
    output logic             last_o
);

    logic [DIV_W-1:0] cnt_q;

    assign last_o    = run_i && (cnt_q == div_last_i);
    assign clk_en_o  = run_i && (cnt_q == '0);
    assign clk_lvl_o = run_i && (cnt_q < div_half_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (!run_i || last_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: counter never passes the active ratio
    a_r2_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> (cnt_q <= div_last_i));

    // R2: strobe lasts one oscillator cycle
    a_r2_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clk_en_o |=> !clk_en_o);

endmodule

// File: rtl/ftg_slot_counter.sv
module ftg_slot_counter
    import ftg_pkg::*;
#(
    parameter int SLOT_W   = 5,
    parameter int ROW_BASE = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic              step_i,
    input  logic [SLOT_W-1:0] slot_last_i,
    input  mux_rate_e         rate_i,
    output logic              frame_end_o,
    output logic              sync_o,
    output logic [SLOT_W-1:0] row_o
);

    logic [SLOT_W-1:0] slot_q;

    assign frame_end_o = step_i && (slot_q == slot_last_i);
    assign sync_o      = run_i && (slot_q == '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            slot_q <= '0;
        end else if (!run_i || frame_end_o) begin
            slot_q <= '0;
        end else if (step_i) begin
            slot_q <= slot_q + 1'b1;
        end
    end

    always_comb begin
        unique case (rate_i)
            MUX_8:   row_o = slot_q & SLOT_W'(ROW_BASE - 1);
            MUX_16:  row_o = slot_q & SLOT_W'(2 * ROW_BASE - 1);
            default: row_o = slot_q;
        endcase
    end

    // R4: slot stays inside the active frame length
    a_r4_slot_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> (slot_q <= slot_last_i));

endmodule

// File: rtl/frame_timing_gen.sv
module frame_timing_gen
    import ftg_pkg::*;
#(
    parameter int DIV_STD   = 6,
    parameter int DIV_ALT   = 8,
    parameter int FRAME_STD = 32,
    parameter int FRAME_ALT = 24,
    parameter int ROW_BASE  = 8
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] mux_sel_i,
    output logic       cas_clk_o,
    output logic       cas_clk_en_o,
    output logic       sync_o,
    output logic [4:0] row_idx_o
);

    localparam int DIV_MAX   = (DIV_ALT > DIV_STD) ? DIV_ALT : DIV_STD;
    localparam int FRAME_MAX = (FRAME_ALT > FRAME_STD) ? FRAME_ALT : FRAME_STD;
    localparam int DIV_W     = $clog2(DIV_MAX);
    localparam int SLOT_W    = $clog2(FRAME_MAX);

    logic              run;
    mux_rate_e         rate;
    logic [DIV_W-1:0]  div_last;
    logic [DIV_W-1:0]  div_half;
    logic [SLOT_W-1:0] slot_last;
    logic              step;
    logic              frame_end;
    logic [SLOT_W-1:0] row;

    ftg_ctrl #(
        .DIV_STD  (DIV_STD),
        .DIV_ALT  (DIV_ALT),
        .FRAME_STD(FRAME_STD),
        .FRAME_ALT(FRAME_ALT),
        .DIV_W    (DIV_W),
        .SLOT_W   (SLOT_W)
    ) u_ctrl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rate_req_i (mux_rate_e'(mux_sel_i)),
        .frame_end_i(frame_end),
        .run_o      (run),
        .rate_o     (rate),
        .div_last_o (div_last),
        .div_half_o (div_half),
        .slot_last_o(slot_last)
    );

    ftg_prescaler #(
        .DIV_W(DIV_W)
    ) u_pre (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (run),
        .div_last_i(div_last),
        .div_half_i(div_half),
        .clk_en_o  (cas_clk_en_o),
        .clk_lvl_o (cas_clk_o),
        .last_o    (step)
    );

    ftg_slot_counter #(
        .SLOT_W  (SLOT_W),
        .ROW_BASE(ROW_BASE)
    ) u_slot (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (run),
        .step_i     (step),
        .slot_last_i(slot_last),
        .rate_i     (rate),
        .frame_end_o(frame_end),
        .sync_o     (sync_o),
        .row_o      (row)
    );

    assign row_idx_o = 5'(row);

    // R3: sync only starts at a frame boundary or at start-up
    a_r3_sync_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sync_o) |-> ($past(frame_end) || !$past(run)));

    // R5: row index stays below the active row count
    a_r5_row_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run |-> (int'(row_idx_o) < (int'(rate) + 1) * ROW_BASE));

    // R2: a strobe cycle is always a high clock level
    a_r2_strobe_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cas_clk_en_o |-> cas_clk_o);

endmodule

// File: tb/sim_frame_timing_gen.sv
module sim_frame_timing_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mux = 2'd3;
    logic       cclk, cen, sync;
    logic [4:0] row;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // model state
    bit m_run = 0;
    int m_sel = 3, m_pre = 0, m_slot = 0;
    int cyc = 0, last_rise = 0, en_cnt = 0, exp_len = 0;
    bit rise_valid = 0;
    bit prev_sync = 0;
    int rises = 0;

    always #2.5 clk = ~clk;

    frame_timing_gen u0 (
        .clk_i(clk), .rst_ni(rst_n), .mux_sel_i(mux),
        .cas_clk_o(cclk), .cas_clk_en_o(cen), .sync_o(sync), .row_idx_o(row)
    );

    function automatic int divf(int s); return (s == 2) ? 8 : 6; endfunction
    function automatic int lenf(int s); return (s == 2) ? 24 : 32; endfunction
    function automatic int rowsf(int s); return (s + 1) * 8; endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic compare_outputs();
        int e_en, e_clk, e_sync, e_row;
        if (!m_run) begin
            e_en = 0; e_clk = 0; e_sync = 0; e_row = 0;
            chk(cen == 0 && cclk == 0 && sync == 0 && row == 0, "R1 idle outputs",
                {cen, cclk, sync, row}, 0);
            return;
        end
        e_en   = (m_pre == 0);
        e_clk  = (m_pre < divf(m_sel) / 2);
        e_sync = (m_slot == 0);
        e_row  = m_slot % rowsf(m_sel);
        chk(int'(cen) == e_en, "R2 strobe", cen, e_en);
        chk(int'(cclk) == e_clk, "R2 clock level", cclk, e_clk);
        chk(int'(sync) == e_sync, "R3 sync", sync, e_sync);
        chk(int'(row) == e_row, "R5 row index", row, e_row);
    endtask

    task automatic tick();
        @(posedge clk);
        if (rst_n) begin
            if (!m_run) begin
                m_run = 1; m_sel = mux; m_pre = 0; m_slot = 0;
            end else if (m_pre == divf(m_sel) - 1) begin
                m_pre = 0;
                if (m_slot == lenf(m_sel) - 1) begin
                    m_slot = 0; m_sel = mux;   // R6 adopt at boundary
                end else begin
                    m_slot++;
                end
            end else begin
                m_pre++;
            end
        end
        #1;
        cyc++;
        compare_outputs();
        if (sync && !prev_sync) begin
            rises++;
            if (rise_valid) begin
                chk(cyc - last_rise == 192, "R3 sync spacing", cyc - last_rise, 192);
                chk(en_cnt == exp_len, "R4 strobes per frame", en_cnt, exp_len);
            end
            rise_valid = 1; last_rise = cyc; en_cnt = 0; exp_len = lenf(m_sel);
        end
        if (cen) en_cnt++;
        prev_sync = sync;
    endtask

    task automatic do_reset();
        rst_n = 0;
        #1;
        m_run = 0; rise_valid = 0; prev_sync = 0;
        chk(cen == 0 && sync == 0 && cclk == 0 && row == 0, "R1 async reset",
            {cen, cclk, sync, row}, 0);
        repeat (3) tick();
        rst_n = 1;
        #0.5;
        chk(cen == 0 && sync == 0 && cclk == 0, "R1 before first edge", {cen, cclk, sync}, 0);
        tick();
        chk(cen == 1 && sync == 1 && row == 0, "R7 first strobe and sync", {cen, sync}, 3);
    endtask

    task automatic wait_rise();
        int n = 0;
        do begin tick(); n++; end while (!(sync && last_rise == cyc) && n < 1000);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int s;
        int rises_seen;
        void'($urandom(32'd4242));
        mux = 2'd3;
        repeat (2) tick();
        chk(cen == 0 && sync == 0 && row == 0, "R1 reset state", {cen, sync, row}, 0);
        rst_n = 1;
        tick();
        chk(sync == 1 && cen == 1, "R7 start after reset", {sync, cen}, 3);

        // each rate for two full frames
        for (int r = 0; r < 4; r++) begin
            mux = 2'(r);
            repeat (3) wait_rise();
        end

        // R6 directed: mid-frame switch 1:32 -> 1:24 keeps current frame at 32
        mux = 2'd3;
        repeat (2) wait_rise();
        repeat (50) tick();
        mux = 2'd2;
        wait_rise();
        chk(m_sel == 2, "R6 adopted at boundary", m_sel, 2);
        wait_rise();
        // R6 switch on last cycle before boundary
        mux = 2'd0;
        repeat (191) tick();
        mux = 2'd1;
        tick();
        chk(int'(row) == 0 && sync == 1, "R6 last-cycle change", row, 0);
        repeat (2) wait_rise();

        // mid-frame reset
        repeat (77) tick();
        do_reset();

        // constrained random
        for (int i = 0; i < 40; i++) begin
            mux = 2'($urandom % 4);
            s = 1 + ($urandom % 400);
            repeat (s) tick();
            if (i == 20) do_reset();
        end

        // R8 continuous toggling
        begin
            int edges = 0;
            bit pv = cclk;
            repeat (96) begin
                tick();
                if (cclk && !pv) edges++;
                pv = cclk;
            end
            chk(edges >= 12, "R8 clock keeps toggling", edges, 12);
        end
        rises_seen = rises;
        chk(rises_seen > 20, "R3 sync pulses seen", rises_seen, 21);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule